// File: doc/BRIEF.md
# Sensitivity Map Lookup Engine

This engine decides whether an upset found in configuration memory matters to the running design. A requester gives it the upset location as a frame number, a byte number within the frame and a bit number within that byte. The engine then walks a three-level table held in an external byte-addressed lookup memory. First it reads a frame record. The record supplies a data offset and the index of the offset map that applies to the frame. Next it reads a per-bit 16-bit offset. Last it reads one sensitivity byte, and it selects a single bit from that byte. That bit is returned as the critical flag.

Each read address depends on data returned by the read before it, so the engine keeps exactly one memory read outstanding and walks the table in a fixed order. Three base addresses and the length of one offset map array are supplied as static configuration inputs. All address arithmetic is 32-bit unsigned and wraps silently. Multi-byte fields are assembled little-endian from successive byte reads.

Top module: `smap_lookup_engine`

## Requirements
- R1: After a synchronous reset, busy, done, mem_rd_req and critical are all 0.
- R2: A start seen while idle raises busy and mem_rd_req on the next clock edge. The first read address is cfg_frame_base + 4*frame_num.
- R3: The frame record is read as four bytes at consecutive rising addresses and assembled little-endian. Bits 31:16 of the record are the sensitivity data offset, and bits 15:0 are the offset map array index.
- R4: The offset value is read as two bytes, low byte first, starting at cfg_offmap_base + index*cfg_offmap_len + 2*(byte_num*8 + bit_num).
- R5: The sensitivity byte is read from cfg_sens_base + data offset + (offset value >> 3).
- R6: critical equals bit (offset value bits 2:0) of the sensitivity byte. A 1 means the upset is critical and a 0 means it is not.
- R7: mem_rd_req stays high for the whole lookup, and only while busy. mem_rd_addr holds steady until a mem_rd_valid pulse completes the read. All seven reads are issued in the order given above.
- R8: done is a one-cycle pulse in the cycle busy falls. critical changes only in a done cycle and holds until the next done.
- R9: A start seen while busy is ignored. The running lookup keeps its original location and result.
- R10: Address sums wrap modulo 2^32 and are not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a lookup (accepted only when idle) |
| frame_num | input | FRAME_W | Upset frame number |
| byte_num | input | BYTE_W | Upset byte number within frame |
| bit_num | input | 3 | Upset bit number within byte |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| critical | output | 1 | Result flag, valid from done onward |
| mem_rd_req | output | 1 | Read request, held until mem_rd_valid |
| mem_rd_addr | output | 32 | Byte address of the pending read |
| mem_rd_valid | input | 1 | Read completion pulse |
| mem_rd_data | input | 8 | Byte returned with mem_rd_valid |
| cfg_frame_base | input | 32 | Frame record table base address |
| cfg_offmap_base | input | 32 | Offset map base address |
| cfg_offmap_len | input | 32 | Byte length of one offset map array |
| cfg_sens_base | input | 32 | Sensitivity data base address |

## Verification
Suppose the engine assembles a field wrongly, for example by swapping bytes, putting the bytes in the wrong lane or dropping the index. The fault first shows as a wrong mem_rd_addr on the very next read, within one memory latency of the corrupted byte. It shows well before the result. A wrong byte counter gives the wrong number of reads, so busy and done leave their expected cycles. A slip in the final bit select shows only in critical at the done pulse. For that reason the lookups use sensitivity bytes whose neighbouring bits differ.

// File: rtl/smap_pkg.sv
package smap_pkg;
    localparam int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FINFO  = 2'd1,
        ST_OFFMAP = 2'd2,
        ST_SENS   = 2'd3
    } smap_state_e;

    localparam int FINFO_BYTES  = 4;
    localparam int OFFMAP_BYTES = 2;
endpackage

// File: rtl/smap_byte_asm.sv
module smap_byte_asm #(
    parameter  int NBYTES = 4,
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int WW     = NBYTES * 8
) (
    input  logic [WW-1:0] word_i,
    input  logic [IW-1:0] sel_i,
    input  logic          wr_i,
    input  logic [7:0]    byte_i,
    output logic [WW-1:0] word_o
);
    // one lane per byte; lane 0 is the lowest address (little-endian)
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign word_o[g*8 +: 8] = (wr_i && (sel_i == IW'(g))) ? byte_i : word_i[g*8 +: 8];
    end
endmodule

// File: rtl/smap_addr_gen.sv
module smap_addr_gen
    import smap_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int BYTE_W  = 16
) (
    input  smap_state_e        phase_i,
    input  logic [1:0]         idx_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [2:0]         bit_i,
    input  logic [15:0]        data_off_i,
    input  logic [15:0]        map_idx_i,
    input  logic [15:0]        oval_i,
    input  addr_t              frame_base_i,
    input  addr_t              offmap_base_i,
    input  addr_t              offmap_len_i,
    input  addr_t              sens_base_i,
    output addr_t              addr_o
);
    addr_t rec_off;
    addr_t bit_slot;
    addr_t map_off;
    addr_t base;

    always_comb begin
        rec_off  = addr_t'(frame_i) << 2;
        bit_slot = ((addr_t'(byte_i) << 3) + addr_t'(bit_i)) << 1;
        map_off  = addr_t'(map_idx_i) * offmap_len_i;
        case (phase_i)
            ST_FINFO:  base = frame_base_i + rec_off;
            ST_OFFMAP: base = offmap_base_i + map_off + bit_slot;
            ST_SENS:   base = sens_base_i + addr_t'(data_off_i) + addr_t'(oval_i >> 3);
            default:   base = '0;
        endcase
        addr_o = base + addr_t'(idx_i);
    end
endmodule

// File: rtl/smap_lookup_engine.sv
module smap_lookup_engine
    import smap_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int BYTE_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic [BYTE_W-1:0]  byte_num,
    input  logic [2:0]         bit_num,
    output logic               busy,
    output logic               done,
    output logic               critical,
    output logic               mem_rd_req,
    output logic [31:0]        mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [7:0]         mem_rd_data,
    input  logic [31:0]        cfg_frame_base,
    input  logic [31:0]        cfg_offmap_base,
    input  logic [31:0]        cfg_offmap_len,
    input  logic [31:0]        cfg_sens_base
);
    localparam int FW = FINFO_BYTES * 8;
    localparam int OW = OFFMAP_BYTES * 8;
    localparam logic [1:0] FINFO_LAST  = 2'(FINFO_BYTES - 1);
    localparam logic [1:0] OFFMAP_LAST = 2'(OFFMAP_BYTES - 1);

    typedef struct packed {
        smap_state_e        st;
        logic [1:0]         idx;
        logic               req;
        logic               done;
        logic               crit;
        logic [FRAME_W-1:0] frame;
        logic [BYTE_W-1:0]  bytn;
        logic [2:0]         bitn;
        logic [FW-1:0]      fword;
        logic [OW-1:0]      oval;
        addr_t              addr;
    } regs_t;

    regs_t r_q, r_nx, r_d;
    logic [FW-1:0] fword_asm;
    logic [OW-1:0] oval_asm;
    addr_t         next_addr;

    smap_byte_asm #(.NBYTES(FINFO_BYTES)) u_finfo_asm (
        .word_i (r_q.fword),
        .sel_i  (r_q.idx),
        .wr_i   ((r_q.st == ST_FINFO) && mem_rd_valid),
        .byte_i (mem_rd_data),
        .word_o (fword_asm)
    );

    smap_byte_asm #(.NBYTES(OFFMAP_BYTES)) u_oval_asm (
        .word_i (r_q.oval),
        .sel_i  (r_q.idx[0]),
        .wr_i   ((r_q.st == ST_OFFMAP) && mem_rd_valid),
        .byte_i (mem_rd_data),
        .word_o (oval_asm)
    );

    // sequencing: next values except the address
    always_comb begin
        r_nx      = r_q;
        r_nx.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_nx.st    = ST_FINFO;
                    r_nx.idx   = '0;
                    r_nx.req   = 1'b1;
                    r_nx.frame = frame_num;
                    r_nx.bytn  = byte_num;
                    r_nx.bitn  = bit_num;
                end
            end
            ST_FINFO: begin
                if (mem_rd_valid) begin
                    r_nx.fword = fword_asm;
                    if (r_q.idx == FINFO_LAST) begin
                        r_nx.st  = ST_OFFMAP;
                        r_nx.idx = '0;
                    end else begin
                        r_nx.idx = r_q.idx + 2'd1;
                    end
                end
            end
            ST_OFFMAP: begin
                if (mem_rd_valid) begin
                    r_nx.oval = oval_asm;
                    if (r_q.idx == OFFMAP_LAST) begin
                        r_nx.st  = ST_SENS;
                        r_nx.idx = '0;
                    end else begin
                        r_nx.idx = r_q.idx + 2'd1;
                    end
                end
            end
            ST_SENS: begin
                if (mem_rd_valid) begin
                    r_nx.crit = mem_rd_data[r_q.oval[2:0]];
                    r_nx.done = 1'b1;
                    r_nx.req  = 1'b0;
                    r_nx.st   = ST_IDLE;
                end
            end
            default: r_nx.st = ST_IDLE;
        endcase
    end

    smap_addr_gen #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_addr_gen (
        .phase_i       (r_nx.st),
        .idx_i         (r_nx.idx),
        .frame_i       (r_nx.frame),
        .byte_i        (r_nx.bytn),
        .bit_i         (r_nx.bitn),
        .data_off_i    (r_nx.fword[31:16]),
        .map_idx_i     (r_nx.fword[15:0]),
        .oval_i        (r_nx.oval),
        .frame_base_i  (cfg_frame_base),
        .offmap_base_i (cfg_offmap_base),
        .offmap_len_i  (cfg_offmap_len),
        .sens_base_i   (cfg_sens_base),
        .addr_o        (next_addr)
    );

    always_comb begin
        r_d = r_nx;
        if (r_nx.st != ST_IDLE) begin
            r_d.addr = next_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign critical    = r_q.crit;
    assign mem_rd_req  = r_q.req;
    assign mem_rd_addr = r_q.addr;

    // checks on the sequencing above
    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    assert_req_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> busy);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_rd_req));
    assert_crit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(critical));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(r_q.frame) && $stable(r_q.bytn) && $stable(r_q.bitn)));
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && mem_rd_req));
endmodule

// File: tb/smap_lookup_engine_tb_top.sv
module smap_lookup_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_W = 16;
    localparam int BYTE_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [FRAME_W-1:0] frame_num = '0;
    logic [BYTE_W-1:0]  byte_num = '0;
    logic [2:0] bit_num = '0;
    logic busy, done, critical, mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [7:0] mem_rd_data = '0;
    logic [31:0] cfg_frame_base = '0, cfg_offmap_base = '0, cfg_offmap_len = '0, cfg_sens_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smap_lookup_engine #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .frame_num(frame_num),
        .byte_num(byte_num), .bit_num(bit_num), .busy(busy), .done(done),
        .critical(critical), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .cfg_frame_base(cfg_frame_base), .cfg_offmap_base(cfg_offmap_base),
        .cfg_offmap_len(cfg_offmap_len), .cfg_sens_base(cfg_sens_base)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // lookup memory: overrides first, otherwise a hash of the address
    byte unsigned ovr[int unsigned];
    function automatic logic [7:0] mem_byte(input int unsigned a);
        int unsigned h;
        if (ovr.exists(a)) return ovr[a];
        h = a * 32'h9E37_79B1;
        return 8'(h >> 13) ^ 8'(a);
    endfunction

    // reference model state
    int unsigned exp_q[$];
    bit m_busy = 0, m_done = 0, m_crit = 0, m_crit_pend = 0;
    int m_pos = 0;
    int unsigned first_addr = 0;

    function automatic bit ref_lookup(input int unsigned fr, input int unsigned by, input int unsigned bt);
        int unsigned a1, a2, a3, fw, ov;
        logic [7:0] sb;
        a1 = cfg_frame_base + fr * 4;
        fw = 0;
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(a1 + i);
            fw = fw | (int'(mem_byte(a1 + i)) << (8 * i));
        end
        a2 = cfg_offmap_base + (fw & 32'hFFFF) * cfg_offmap_len + 2 * (by * 8 + bt);
        exp_q.push_back(a2);
        exp_q.push_back(a2 + 1);
        ov = int'(mem_byte(a2)) | (int'(mem_byte(a2 + 1)) << 8);
        a3 = cfg_sens_base + (fw >> 16) + (ov >> 3);
        exp_q.push_back(a3);
        sb = mem_byte(a3);
        return sb[ov & 7];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            m_busy = 0; m_done = 0; m_crit = 0; m_pos = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start) begin
                exp_q.delete();
                m_crit_pend = ref_lookup(frame_num, byte_num, bit_num);
                m_busy = 1;
                m_pos = 0;
            end else if (m_busy && mem_rd_valid) begin
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                m_pos++;
                if (exp_q.size() == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_crit = m_crit_pend;
                end
            end
        end
    end

    // memory responder with varying latency; checks each read address
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            mem_rd_valid = 0;
            wait_cnt = 0;
        end else if (mem_rd_valid) begin
            mem_rd_valid = 0;
            wait_cnt = $urandom_range(0, 3);
        end else if (mem_rd_req) begin
            if (wait_cnt == 0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7 read with nothing expected", mem_rd_addr, 0);
                end else if (m_pos == 0) begin
                    first_addr = mem_rd_addr;
                    chk(mem_rd_addr == exp_q[0], "R2 first read address", mem_rd_addr, exp_q[0]);
                end else if (m_pos < 4) begin
                    chk(mem_rd_addr == exp_q[0], "R3 frame record address", mem_rd_addr, exp_q[0]);
                end else if (m_pos < 6) begin
                    chk(mem_rd_addr == exp_q[0], "R4 offset value address", mem_rd_addr, exp_q[0]);
                end else begin
                    chk(mem_rd_addr == exp_q[0], "R5 sensitivity byte address", mem_rd_addr, exp_q[0]);
                end
                mem_rd_data = mem_byte(mem_rd_addr);
                mem_rd_valid = 1;
            end else begin
                wait_cnt--;
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy, "R2 busy", busy, m_busy);
            chk(mem_rd_req == m_busy, "R7 mem_rd_req", mem_rd_req, m_busy);
            chk(done == m_done, "R8 done", done, m_done);
            chk(critical == m_crit, "R8 critical", critical, m_crit);
        end
    end

    task automatic run_lookup(input int unsigned fr, input int unsigned by, input int unsigned bt,
                              input bit poke_busy);
        @(negedge clk);
        frame_num = FRAME_W'(fr);
        byte_num  = BYTE_W'(by);
        bit_num   = 3'(bt);
        start = 1;
        @(negedge clk);
        start = 0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            frame_num = frame_num + 1;
            byte_num  = byte_num + 7;
            bit_num   = bit_num ^ 3'd5;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(done == 0, "R1 done after reset", done, 0);
        chk(mem_rd_req == 0, "R1 req after reset", mem_rd_req, 0);
        chk(critical == 0, "R1 critical after reset", critical, 0);

        // directed table: record 0x0120_0002, offset 0x0035, sensitivity byte at 0x8126
        cfg_frame_base = 32'h1000; cfg_offmap_base = 32'h2000;
        cfg_offmap_len = 32'h40;   cfg_sens_base = 32'h8000;
        ovr[32'h100C] = 8'h02; ovr[32'h100D] = 8'h00;
        ovr[32'h100E] = 8'h20; ovr[32'h100F] = 8'h01;
        ovr[32'h20D4] = 8'h35; ovr[32'h20D5] = 8'h00;
        ovr[32'h8126] = 8'h20;
        run_lookup(3, 5, 2, 0);
        chk(critical == 1, "R6 critical bit set", critical, 1);

        ovr[32'h8126] = 8'hDF;
        run_lookup(3, 5, 2, 0);
        chk(critical == 0, "R6 non-critical bit clear", critical, 0);

        // start while busy must not disturb the running lookup
        ovr[32'h8126] = 8'h20;
        run_lookup(3, 5, 2, 1);
        chk(critical == 1, "R9 lookup unaffected by start while busy", critical, 1);
        repeat (3) @(negedge clk);
        chk(busy == 0, "R9 no second lookup started", busy, 0);

        // wraparound of the first address
        cfg_frame_base = 32'hFFFF_FFF8;
        run_lookup(3, 1, 1, 0);
        chk(first_addr == 32'h4, "R10 frame address wraps", first_addr, 32'h4);

        // assorted locations over the hashed table
        cfg_frame_base = 32'h0004_0000; cfg_offmap_base = 32'h0010_0000;
        cfg_offmap_len = 32'h0000_0800; cfg_sens_base = 32'h0100_0000;
        for (int n = 0; n < 24; n++) begin
            run_lookup($urandom_range(0, 65535), $urandom_range(0, 65535), $urandom_range(0, 7), 0);
            chk(critical == m_crit, "R6 result vs model", critical, m_crit);
        end

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        finished = 1;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule